// File: doc/BRIEF.md
# Half-Duplex Collision and Retry Controller

This block follows one half-duplex Ethernet transmission at a time and decides what happens when the medium reports a collision. A transmission opens with a start pulse. From that pulse on, every byte put on the wire produces a strobe, and the preamble and start-of-frame delimiter bytes are counted as well. A collision is judged against a programmable window that is measured in bytes from the start of transmission. A collision inside the window is an ordinary one and earns another attempt, unless the programmable attempt budget is used up. In that case the frame is dropped as an excessive-collision failure. A collision that arrives after the window closes is reported as late and is never retried.

After each retried collision the block waits a backoff of k slot times before it accepts a new start. For the n-th collision, k is drawn from an on-chip linear-feedback shift register and lies in 0 to 2^min(n,10) − 1. A single-cycle pulse ends the backoff, and the transmit side may then request the medium again. The attempt count is kept across retries of the same frame. It returns to zero on success, on abort, on a late collision and on reset.

Top module: `coll_retry_ctrl`

## Requirements
- R1: While reset is high and in the first cycle after it, all indication outputs are low, backoff_busy_o is low and attempt_o is 0.
- R2: Call b the number of byte strobes accepted since the start pulse, not counting a strobe in the collision cycle. A collision during transmission with b <= win_cfg and attempt_o < retry_lim_cfg raises retry_o for one cycle in the next cycle, increments attempt_o by one and sets backoff_busy_o.
- R3: A collision during transmission with b > win_cfg raises late_coll_o for one cycle, raises no retry, returns attempt_o to 0 and ends the frame.
- R4: An in-window collision while attempt_o >= retry_lim_cfg raises abort_o for one cycle and returns attempt_o to 0. With retry_lim_cfg = 0, the first collision aborts.
- R5: After the n-th retry, backoff_done_o pulses for one cycle once k slot ticks have been counted, with 0 <= k <= 2^min(n,10) − 1. If slot_tick is high every cycle, the pulse comes k+1 cycles after the retry pulse. backoff_busy_o falls in the same cycle.
- R6: tx_done during transmission with no collision raises success_o for one cycle and returns attempt_o to 0.
- R7: When a collision and tx_done arrive in the same cycle, the collision is the one handled and success_o stays low.
- R8: During backoff, tx_start, coll_in and tx_done produce no indication and leave attempt_o unchanged. Outside a transmission, coll_in and tx_done produce no indication. A tx_start seen during backoff does not start a transmission.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_start | input | 1 | Start of a transmission attempt (accepted when idle) |
| byte_strobe | input | 1 | One byte sent, preamble and delimiter included |
| coll_in | input | 1 | Collision seen on the medium |
| tx_done | input | 1 | Transmission finished |
| slot_tick | input | 1 | One slot time elapsed |
| win_cfg | input | 6 | Collision window end, in bytes from start |
| retry_lim_cfg | input | 4 | Attempt limit before abort |
| retry_o | output | 1 | Pulse: collision will be retried |
| late_coll_o | output | 1 | Pulse: collision after the window |
| abort_o | output | 1 | Pulse: excessive collisions, frame dropped |
| success_o | output | 1 | Pulse: frame sent without collision |
| backoff_done_o | output | 1 | Pulse: backoff over, transmit may resume |
| backoff_busy_o | output | 1 | Backoff in progress |
| attempt_o | output | 4 | Collisions counted for the current frame |

## Verification
A collision and a transmit-done can arrive in the same cycle. The bench causes this by raising both inputs in one cycle during a transmission. It then requires a retry pulse and the attempt count to rise by one, with no success pulse. The bench also raises a collision at exactly the window end and one byte past it, and drives the attempt count up to the limit so that the next collision must abort. The random part varies the window, the limit and the frame length against a bench model of the attempt count.

// File: rtl/coll_retry_pkg.sv
package coll_retry_pkg;

    localparam int BO_CAP = 10;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_TX      = 2'd1,
        ST_BACKOFF = 2'd2
    } tx_state_e;

    typedef struct packed {
        logic retry;
        logic late;
        logic abort;
        logic success;
    } outcome_t;

    // Mask of 2^min(n,BO_CAP) - 1 for the n-th collision
    function automatic logic [BO_CAP-1:0] bo_mask(input int n);
        int e;
        logic [BO_CAP:0] tmp;
        e   = (n < BO_CAP) ? n : BO_CAP;
        tmp = ((BO_CAP+1)'(1) << e) - (BO_CAP+1)'(1);
        return tmp[BO_CAP-1:0];
    endfunction

endpackage

// File: rtl/bo_lfsr.sv
module bo_lfsr #(
    parameter int          W    = 16,
    parameter logic [W-1:0] TAPS = 16'hB400,
    parameter logic [W-1:0] SEED = 16'hACE1
) (
    input  logic         clk,
    input  logic         rst,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)       q <= SEED;
        else if (q[0]) q <= (q >> 1) ^ TAPS;
        else           q <= q >> 1;
    end
endmodule

// File: rtl/win_tracker.sv
module win_tracker #(
    parameter int WIN_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             strobe,
    input  logic [WIN_W-1:0] win,
    output logic             in_win
);
    localparam int CNT_W = WIN_W + 1;

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clear)                cnt_q <= '0;
        else if (strobe && cnt_q != '1)  cnt_q <= cnt_q + CNT_W'(1);
    end

    assign in_win = (cnt_q <= CNT_W'(win));
endmodule

// File: rtl/bo_timer.sv
module bo_timer #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         tick,
    output logic         zero
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)                       cnt_q <= '0;
        else if (load)                 cnt_q <= load_val;
        else if (tick && cnt_q != '0)  cnt_q <= cnt_q - W'(1);
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/coll_retry_ctrl.sv
module coll_retry_ctrl
    import coll_retry_pkg::*;
#(
    parameter int WIN_W  = 6,
    parameter int LIM_W  = 4,
    parameter int LFSR_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tx_start,
    input  logic             byte_strobe,
    input  logic             coll_in,
    input  logic             tx_done,
    input  logic             slot_tick,
    input  logic [WIN_W-1:0] win_cfg,
    input  logic [LIM_W-1:0] retry_lim_cfg,
    output logic             retry_o,
    output logic             late_coll_o,
    output logic             abort_o,
    output logic             success_o,
    output logic             backoff_done_o,
    output logic             backoff_busy_o,
    output logic [LIM_W-1:0] attempt_o
);
    localparam int NW = LIM_W + 1;

    tx_state_e         state_q, state_d;
    logic [LIM_W-1:0]  att_q, att_d;
    logic [NW-1:0]     n_next;
    outcome_t          res_c, res_q;
    logic              start_acc, in_win, bo_zero, done_c, done_q;
    logic [LFSR_W-1:0] rnd;
    logic [BO_CAP-1:0] bo_val;

    bo_lfsr #(.W(LFSR_W)) i_lfsr (
        .clk (clk),
        .rst (rst),
        .q   (rnd)
    );

    win_tracker #(.WIN_W(WIN_W)) i_win (
        .clk    (clk),
        .rst    (rst),
        .clear  (start_acc),
        .strobe (byte_strobe && state_q == ST_TX),
        .win    (win_cfg),
        .in_win (in_win)
    );

    bo_timer #(.W(BO_CAP)) i_bo (
        .clk      (clk),
        .rst      (rst),
        .load     (res_c.retry),
        .load_val (bo_val),
        .tick     (slot_tick),
        .zero     (bo_zero)
    );

    assign n_next = NW'(att_q) + NW'(1);
    assign bo_val = rnd[BO_CAP-1:0] & bo_mask(int'(n_next));

    always_comb begin
        state_d   = state_q;
        att_d     = att_q;
        res_c     = '0;
        start_acc = 1'b0;
        done_c    = 1'b0;
        case (state_q)
            ST_IDLE: begin
                if (tx_start) begin
                    start_acc = 1'b1;
                    state_d   = ST_TX;
                end
            end
            ST_TX: begin
                if (coll_in) begin
                    if (!in_win) begin
                        res_c.late = 1'b1;
                        att_d      = '0;
                        state_d    = ST_IDLE;
                    end else if (n_next > NW'(retry_lim_cfg)) begin
                        res_c.abort = 1'b1;
                        att_d       = '0;
                        state_d     = ST_IDLE;
                    end else begin
                        res_c.retry = 1'b1;
                        att_d       = n_next[LIM_W-1:0];
                        state_d     = ST_BACKOFF;
                    end
                end else if (tx_done) begin
                    res_c.success = 1'b1;
                    att_d         = '0;
                    state_d       = ST_IDLE;
                end
            end
            ST_BACKOFF: begin
                if (bo_zero) begin
                    done_c  = 1'b1;
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            att_q   <= '0;
            res_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            att_q   <= att_d;
            res_q   <= res_c;
            done_q  <= done_c;
        end
    end

    assign retry_o        = res_q.retry;
    assign late_coll_o    = res_q.late;
    assign abort_o        = res_q.abort;
    assign success_o      = res_q.success;
    assign backoff_done_o = done_q;
    assign backoff_busy_o = (state_q == ST_BACKOFF);
    assign attempt_o      = att_q;
endmodule

// File: rtl/coll_retry_chk.sv
module coll_retry_chk #(
    parameter int LIM_W = 4
) (
    input logic             clk,
    input logic             rst,
    input logic [LIM_W-1:0] retry_lim_cfg,
    input logic             retry_o,
    input logic             late_coll_o,
    input logic             abort_o,
    input logic             success_o,
    input logic             backoff_done_o,
    input logic             backoff_busy_o,
    input logic [LIM_W-1:0] attempt_o
);
    // R2
    retry_inc_chk: assert property (@(posedge clk) disable iff (rst)
        retry_o |-> (attempt_o == $past(attempt_o) + LIM_W'(1)) && backoff_busy_o);

    // R3
    late_clear_chk: assert property (@(posedge clk) disable iff (rst)
        late_coll_o |-> attempt_o == '0 && !backoff_busy_o);

    // R4
    abort_clear_chk: assert property (@(posedge clk) disable iff (rst)
        abort_o |-> attempt_o == '0 && $past(attempt_o) >= $past(retry_lim_cfg));

    // R5
    done_after_busy_chk: assert property (@(posedge clk) disable iff (rst)
        backoff_done_o |-> $past(backoff_busy_o) && !backoff_busy_o);

    // R6
    success_clear_chk: assert property (@(posedge clk) disable iff (rst)
        success_o |-> attempt_o == '0);

    // R7
    one_outcome_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({retry_o, late_coll_o, abort_o, success_o, backoff_done_o}));

    // R8
    backoff_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(backoff_busy_o) && backoff_busy_o) |->
            $stable(attempt_o) && !retry_o && !late_coll_o && !abort_o && !success_o);
endmodule

bind coll_retry_ctrl coll_retry_chk #(.LIM_W(LIM_W)) i_coll_retry_chk (
    .clk            (clk),
    .rst            (rst),
    .retry_lim_cfg  (retry_lim_cfg),
    .retry_o        (retry_o),
    .late_coll_o    (late_coll_o),
    .abort_o        (abort_o),
    .success_o      (success_o),
    .backoff_done_o (backoff_done_o),
    .backoff_busy_o (backoff_busy_o),
    .attempt_o      (attempt_o)
);

// File: tb/test_coll_retry_ctrl.sv
module test_coll_retry_ctrl;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tx_start = 0, byte_strobe = 0, coll_in = 0, tx_done = 0, slot_tick = 1;
    logic [5:0] win_cfg = 6'd55;
    logic [3:0] retry_lim_cfg = 4'd15;
    logic       retry_o, late_coll_o, abort_o, success_o, backoff_done_o, backoff_busy_o;
    logic [3:0] attempt_o;

    int total = 0;
    int bad   = 0;
    int exp_att = 0;

    always #5 clk = ~clk;

    coll_retry_ctrl i_coll_retry_ctrl (
        .clk(clk), .rst(rst), .tx_start(tx_start), .byte_strobe(byte_strobe),
        .coll_in(coll_in), .tx_done(tx_done), .slot_tick(slot_tick),
        .win_cfg(win_cfg), .retry_lim_cfg(retry_lim_cfg),
        .retry_o(retry_o), .late_coll_o(late_coll_o), .abort_o(abort_o),
        .success_o(success_o), .backoff_done_o(backoff_done_o),
        .backoff_busy_o(backoff_busy_o), .attempt_o(attempt_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int mask_of(input int n);
        int e;
        e = (n < 10) ? n : 10;
        return (1 << e) - 1;
    endfunction

    function automatic int flags();
        return {28'd0, retry_o, late_coll_o, abort_o, success_o};
    endfunction

    // All tasks begin and end at a falling edge.
    task automatic start_frame();
        tx_start = 1; @(negedge clk); tx_start = 0;
    endtask

    task automatic send_bytes(input int n);
        for (int i = 0; i < n; i++) begin
            byte_strobe = 1; @(negedge clk);
        end
        byte_strobe = 0;
    endtask

    task automatic finish_attempt(input logic c, input logic d);
        coll_in = c; tx_done = d; @(negedge clk); coll_in = 0; tx_done = 0;
    endtask

    task automatic wait_backoff(input int n);
        int d;
        d = 0;
        for (int i = 0; i < 1100; i++) begin
            @(negedge clk); d++;
            if (backoff_done_o) break;
        end
        chk("R5 backoff within range", (backoff_done_o && (d - 1) <= mask_of(n)) ? 1 : 0, 1);
        chk("R5 busy falls with done", backoff_busy_o, 0);
        @(negedge clk);
        chk("R5 done is one pulse", backoff_done_o, 0);
    endtask

    // Collision outcome predicted from bytes, window, limit and model count
    task automatic frame_collide(input int nbytes, input logic with_done);
        int exp_f;
        start_frame();
        send_bytes(nbytes);
        finish_attempt(1'b1, with_done);
        if (nbytes > int'(win_cfg)) begin
            exp_f = 4; exp_att = 0;                      // R3 late
            chk("R3 late flags", flags(), exp_f);
        end else if (exp_att >= int'(retry_lim_cfg)) begin
            exp_f = 2; exp_att = 0;                      // R4 abort
            chk("R4 abort flags", flags(), exp_f);
        end else begin
            exp_f = 8; exp_att++;                        // R2 retry
            chk("R2 retry flags", flags(), exp_f);
        end
        chk("R2 attempt count", int'(attempt_o), exp_att);
        if (exp_f == 8) wait_backoff(exp_att);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R1 during reset
        chk("R1 flags in reset", flags(), 0);
        chk("R1 attempt in reset", int'(attempt_o), 0);
        rst = 0;
        @(negedge clk);
        chk("R1 flags after reset", flags(), 0);
        chk("R1 busy after reset", backoff_busy_o, 0);
        chk("R1 attempt after reset", int'(attempt_o), 0);

        // R2 at window end, then up to limit 3 and R4 abort on the fourth
        win_cfg = 6'd55; retry_lim_cfg = 4'd3;
        frame_collide(55, 1'b0);
        frame_collide(10, 1'b0);
        frame_collide(0, 1'b0);
        frame_collide(20, 1'b0);
        chk("R4 abort after limit", int'(attempt_o), 0);

        // R3 one byte past the window
        frame_collide(1, 1'b0);
        frame_collide(56, 1'b0);
        chk("R3 late clears attempts", int'(attempt_o), 0);

        // R6 success
        start_frame(); send_bytes(30); finish_attempt(1'b0, 1'b1);
        chk("R6 success flags", flags(), 1);
        chk("R6 attempt cleared", int'(attempt_o), 0);

        // R7 collision and done together
        retry_lim_cfg = 4'd15;
        frame_collide(5, 1'b1);
        chk("R7 collision wins over done", int'(attempt_o), 1);

        // R8 inputs ignored during backoff, tx_start not latched
        slot_tick = 0;
        start_frame(); send_bytes(3); finish_attempt(1'b1, 1'b0);
        chk("R8 retry before hold", flags(), 8);
        exp_att = 2;
        tx_start = 1; coll_in = 1; tx_done = 1; @(negedge clk);
        tx_start = 0; coll_in = 0; tx_done = 0;
        chk("R8 no outcome in backoff", flags(), 0);
        chk("R8 attempt held in backoff", int'(attempt_o), 2);
        slot_tick = 1;
        if (!backoff_done_o) begin
            for (int i = 0; i < 1100; i++) begin
                @(negedge clk);
                if (backoff_done_o) break;
            end
        end
        chk("R8 backoff ends", backoff_done_o, 1);
        @(negedge clk);
        finish_attempt(1'b1, 1'b1);
        chk("R8 idle ignores coll and done", flags(), 0);
        chk("R8 idle attempt kept", int'(attempt_o), 2);

        // R4 limit 0 aborts the first collision
        start_frame(); send_bytes(2); finish_attempt(1'b0, 1'b1);
        exp_att = 0;
        retry_lim_cfg = 4'd0;
        frame_collide(4, 1'b0);

        // Random frames
        for (int f = 0; f < 120; f++) begin
            int nb;
            win_cfg       = 6'($urandom_range(0, 63));
            retry_lim_cfg = 4'($urandom_range(0, 6));
            nb            = $urandom_range(0, 80);
            if ($urandom_range(0, 3) == 0) begin
                start_frame(); send_bytes(nb); finish_attempt(1'b0, 1'b1);
                exp_att = 0;
                chk("R6 random success", flags(), 1);
                chk("R6 random attempt", int'(attempt_o), 0);
            end else begin
                frame_collide(nb, 1'($urandom_range(0, 1)));
            end
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule